// File: doc/BRIEF.md
# Auto-Reload Up-Counter Timer with Debug Freeze

This block is a 32-bit timer that counts upward on a functional clock enable. When the count leaves its all-ones value it is reloaded from a programmable start value, and a sticky overflow flag is raised. The flag is gated by an enable bit to form the interrupt line. An optional power-of-two divider slows the count. The overflow period, in counter steps, is `0xFFFFFFFF - load + 1`. For example, a start value of `0xFFFFB500` gives 19200 steps, which is 1 ms on a 19.2 MHz enable.

A debug-halt input stops the timer while a debugger holds the processor. This applies only when software has left the free-run flag cleared. The halt acts on its own, apart from the software run bit. Software reaches the timer through one register port with valid/ready handshaking. The port never applies back-pressure: `reg_ready` is always high, so every valid beat is taken in the cycle it is offered. A beat with `reg_write` high is a write. Read data is combinational from `reg_addr` and has no side effects.

Top module: `reload_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With run set and the divider off, the count rises by one on each cycle in which `tick_en` is high, and holds when it is low.
- R3: Control bit 0 is run. While it is 0 the count holds its value. Setting it to 1 resumes counting from that value.
- R4: A step taken at count `0xFFFFFFFF` loads the count from the load register. The overflow period is therefore `0xFFFFFFFF - load + 1` steps.
- R5: Control bit 5 enables the divider. Control bits 4:2 hold n, and the count then steps once per 2^(n+1) enabled ticks. Any write to the control register restarts the divider phase.
- R6: When the free-run flag (bit 0 at address 1) is 0 and `dbg_halt` is high, neither the count nor the divider phase moves.
- R7: When the free-run flag is 1, `dbg_halt` has no effect on counting.
- R8: Each reload sets status bit 0 at address 4. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A reload in the same cycle as a clear leaves the bit set.
- R9: `irq` equals status bit 0 ANDed with interrupt-enable bit 0 at address 5.
- R10: A write to address 3 sets the count directly and overrides any step in that cycle. Load and control writes act from the next cycle onward, so a reload in the write cycle uses the old load value.
- R11: The register map is: 0 control, 1 config, 2 load, 3 count, 4 status, 5 interrupt enable. Addresses 6 and 7 read zero and ignore writes. `reg_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Functional clock enable |
| dbg_halt | input | 1 | Debugger has halted the processor |
| reg_valid | input | 1 | Register beat valid |
| reg_ready | output | 1 | Always 1 |
| reg_write | input | 1 | Beat is a write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt |

## Verification
Some events are hard to bring about from the ports: a reload that falls in the same cycle as a status clear or a load write. The same holds for a reload reached through the largest divider ratio while the halt input toggles. The stimulus first writes the count to all-ones, then issues the clear or load write in the very next beat, so the collision lands on a known cycle. The largest-ratio case runs the divider for several hundred cycles with `dbg_halt` changing, under both settings of the free-run flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W      = 3;
  localparam int CTL_RUN    = 0;
  localparam int CTL_SEL_LO = 2;
  localparam int CTL_PRE    = 5;
  localparam int CTL_W      = 6;
  typedef enum logic [2:0] {
    A_CTL = 3'd0, A_CFG = 3'd1, A_LOAD = 3'd2,
    A_COUNT = 3'd3, A_STAT = 3'd4, A_IEN = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(parameter int DW = 32) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     cnt,
  input  logic              stat,
  output logic [DW-1:0]     rdata,
  output logic [CTL_W-1:0]  ctl,
  output logic              free_run,
  output logic [DW-1:0]     load,
  output logic              ien,
  output logic              ctl_wr,
  output logic              cnt_wr,
  output logic              stat_w1c
);
  assign ctl_wr   = wr_en && (addr == A_CTL);
  assign cnt_wr   = wr_en && (addr == A_COUNT);
  assign stat_w1c = wr_en && (addr == A_STAT) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; free_run <= 1'b0; load <= '0; ien <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        A_CTL:   ctl      <= wdata[CTL_W-1:0];
        A_CFG:   free_run <= wdata[0];
        A_LOAD:  load     <= wdata;
        A_IEN:   ien      <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTL:   rdata[CTL_W-1:0] = ctl;
      A_CFG:   rdata[0] = free_run;
      A_LOAD:  rdata = load;
      A_COUNT: rdata = cnt;
      A_STAT:  rdata[0] = stat;
      A_IEN:   rdata[0] = ien;
      default: rdata = '0;
    endcase
  end

  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > 3'd5) |=> ($stable(ctl) && $stable(load) && $stable(free_run) && $stable(ien)));
endmodule

// File: rtl/tmr_gate.sv
module tmr_gate
  import tmr_pkg::*;
#(parameter int DIV_W = 1 << SEL_W) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             dbg_halt,
  input  logic             free_run,
  input  logic             run,
  input  logic             pre_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             ctl_wr,
  output logic             step
);
  logic             frozen, adv, last;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W:0]   sh;
  logic [DIV_W:0]   lim;

  assign frozen = dbg_halt && !free_run;
  assign adv    = run && tick_en && !frozen;
  assign sh     = {1'b0, sel} + {{SEL_W{1'b0}}, 1'b1};
  assign lim    = (DIV_W+1)'(1) << sh;
  assign last   = ({1'b0, div_q} == lim - (DIV_W+1)'(1));
  assign step   = adv && (!pre_en || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (ctl_wr || !pre_en) div_q <= '0;
    else if (adv)              div_q <= last ? '0 : div_q + DIV_W'(1);
  end

  // R5
  div_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_en |-> ({1'b0, div_q} < lim));
  // R5
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && step && !ctl_wr) |=> !step);
  // R6
  halt_no_div_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !ctl_wr) |=> $stable(div_q));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(parameter int DW = 32) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [DW-1:0] load,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wdata,
  input  logic          stat_w1c,
  output logic [DW-1:0] cnt,
  output logic          ovf_st
);
  logic wrap;
  assign wrap = step && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ovf_st <= 1'b0;
    end else begin
      if (cnt_wr)    cnt <= cnt_wdata;
      else if (step) cnt <= wrap ? load : cnt + DW'(1);
      if (wrap)          ovf_st <= 1'b1;
      else if (stat_w1c) ovf_st <= 1'b0;
    end
  end

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cnt_wr) |=> (cnt == $past(load) && ovf_st));
  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !(&cnt) && !cnt_wr) |=> (cnt == $past(cnt) + DW'(1)));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_wr) |=> $stable(cnt));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_st && !stat_w1c) |=> ovf_st);
  // R10
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(cnt_wdata)));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import tmr_pkg::*;
#(parameter int DW = 32) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          dbg_halt,
  input  logic          reg_valid,
  output logic          reg_ready,
  input  logic          reg_write,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [CTL_W-1:0] ctl;
  logic [DW-1:0]    load, cnt;
  logic free_run, ien, ctl_wr, cnt_wr, stat_w1c, step, ovf_st, wr_en;

  assign reg_ready = 1'b1;
  assign wr_en     = reg_valid && reg_write;

  tmr_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .cnt(cnt), .stat(ovf_st), .rdata(reg_rdata), .ctl(ctl), .free_run(free_run),
    .load(load), .ien(ien), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr), .stat_w1c(stat_w1c));

  tmr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
    .free_run(free_run), .run(ctl[CTL_RUN]), .pre_en(ctl[CTL_PRE]),
    .sel(ctl[CTL_SEL_LO +: SEL_W]), .ctl_wr(ctl_wr), .step(step));

  tmr_count #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(load), .cnt_wr(cnt_wr),
    .cnt_wdata(reg_wdata), .stat_w1c(stat_w1c), .cnt(cnt), .ovf_st(ovf_st));

  assign irq = ovf_st && ien;

  // R6
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !free_run && !cnt_wr) |=> $stable(cnt));
  // R7
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && ctl[CTL_RUN] && !ctl[CTL_PRE] && tick_en && !cnt_wr && !(&cnt))
      |=> (cnt == $past(cnt) + DW'(1)));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ien && ovf_st));
endmodule

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, dbg_halt = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic reg_ready, irq;
  logic [31:0] reg_rdata;

  reload_timer u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model state
  bit [5:0]  m_ctl;
  bit        m_free, m_ien, m_st;
  bit [31:0] m_load, m_cnt;
  int        m_ps;
  int        compared = 0, mismatched = 0, cycles = 0, tick_mod = 0, tk = 0;
  bit        done = 0;
  string     tag = "R1";
  bit [2:0]  rot = 0;

  function automatic bit [31:0] m_read(bit [2:0] a);
    case (a)
      3'd0: return {26'd0, m_ctl};
      3'd1: return {31'd0, m_free};
      3'd2: return m_load;
      3'd3: return m_cnt;
      3'd4: return {31'd0, m_st};
      3'd5: return {31'd0, m_ien};
      default: return 32'd0;
    endcase
  endfunction

  bit wr, adv, stp, ovf;
  int lim, ps_n;
  bit [31:0] c_n;
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ctl = 0; m_free = 0; m_ien = 0; m_st = 0; m_load = 0; m_cnt = 0; m_ps = 0;
    end else begin
      wr  = reg_valid && reg_write;
      adv = m_ctl[0] && tick_en && !(dbg_halt && !m_free);
      stp = 0; ps_n = m_ps;
      if (!m_ctl[5]) begin
        ps_n = 0;
        stp = adv;
      end else if (adv) begin
        lim = 1 << (int'(m_ctl[4:2]) + 1);
        if (m_ps == lim - 1) begin stp = 1; ps_n = 0; end
        else ps_n = m_ps + 1;
      end
      ovf = stp && (m_cnt == 32'hFFFF_FFFF);
      c_n = m_cnt;
      if (stp) c_n = ovf ? m_load : m_cnt + 1;
      if (wr) begin
        case (reg_addr)
          3'd0: begin m_ctl = reg_wdata[5:0]; ps_n = 0; end
          3'd1: m_free = reg_wdata[0];
          3'd2: m_load = reg_wdata;
          3'd3: c_n = reg_wdata;
          3'd4: if (reg_wdata[0]) m_st = 0;
          3'd5: m_ien = reg_wdata[0];
          default: ;
        endcase
      end
      if (ovf) m_st = 1;
      m_cnt = c_n; m_ps = ps_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (reg_rdata !== m_read(reg_addr)) begin
        mismatched++;
        $display("FAIL %s: addr %0d rdata=%h expected %h", tag, reg_addr, reg_rdata, m_read(reg_addr));
      end
      compared++;
      if (irq !== (m_st && m_ien)) begin
        mismatched++;
        $display("FAIL %s: irq=%b expected %b", tag, irq, m_st && m_ien);
      end
      compared++;
      if (reg_ready !== 1'b1) begin
        mismatched++;
        $display("FAIL R11: reg_ready=%b expected 1", reg_ready);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      reg_valid = 0; reg_write = 0; reg_addr = rot; rot = rot + 3'd1;
      tk++;
      tick_en = (tick_mod == 0) ? 1'b1 : ((tk % tick_mod) != 0);
    end
  endtask

  task automatic put(bit [2:0] a, bit [31:0] d);
    @(negedge clk); #1;
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1; rst_n = 1;
    tag = "R1"; idle(8);                               // R1 reset values
    tag = "R11"; put(3'd7, 32'hFFFF_FFFF); put(3'd6, 32'h1234); idle(8);
    @(negedge clk); #1; reg_valid = 1; reg_write = 0; reg_addr = 3'd0; idle(2);
    tag = "R2"; tick_mod = 3; put(3'd0, 32'h1); idle(30);
    tick_mod = 0; idle(10);
    tag = "R3"; put(3'd0, 32'h0); idle(12); put(3'd0, 32'h1); idle(12);
    tag = "R4"; put(3'd5, 32'h1); put(3'd2, 32'hFFFF_FFF0); put(3'd3, 32'hFFFF_FFFC); idle(50);
    tag = "R8"; put(3'd4, 32'h0); idle(4); put(3'd4, 32'h1); idle(4);
    put(3'd3, 32'hFFFF_FFFF); put(3'd4, 32'h1); idle(6);   // set wins over clear
    tag = "R9"; put(3'd5, 32'h0); idle(4); put(3'd5, 32'h1); idle(4);
    put(3'd4, 32'h1); idle(4);
    tag = "R10"; put(3'd3, 32'h0000_0100); idle(4);
    put(3'd3, 32'hFFFF_FFFF); put(3'd2, 32'hFFFF_FF00); idle(8);  // reload uses old load
    tag = "R5";
    for (int n = 0; n < 3; n++) begin put(3'd0, 32'h21 | (n << 2)); idle(40); end
    tick_mod = 4; put(3'd0, 32'h21 | (2 << 2)); idle(40); tick_mod = 0;
    put(3'd3, 32'hFFFF_FFF0); put(3'd0, 32'h21 | (7 << 2)); idle(300);
    put(3'd0, 32'h21 | (7 << 2)); idle(300);               // phase restart
    put(3'd3, 32'hFFFF_FFFE); put(3'd0, 32'h21 | (6 << 2)); idle(300);
    tag = "R6"; put(3'd0, 32'h21); idle(5);
    dbg_halt = 1; idle(20); dbg_halt = 0; idle(5);
    put(3'd0, 32'h1); dbg_halt = 1; idle(10); dbg_halt = 0; idle(4);
    put(3'd0, 32'h21 | (7 << 2)); put(3'd3, 32'hFFFF_FFFF);
    for (int k = 0; k < 30; k++) begin dbg_halt = k[0]; idle(23); end
    dbg_halt = 0;
    tag = "R7"; put(3'd0, 32'h1); put(3'd1, 32'h1); dbg_halt = 1; idle(20);
    put(3'd0, 32'h21 | (1 << 2)); idle(30); dbg_halt = 0; put(3'd1, 32'h0); idle(10);
    finish_run();
  end
endmodule